// File: doc/BRIEF.md
# Programmable Sample Rate Divider

This block turns a free-running serial interface clock into two timing strobes for a sampled-data channel. It watches the serial clock and treats each rising and each falling transition as one half-period event. After every D half-periods it raises an oversampling strobe for one cycle. On every 64th oversampling strobe it also raises a sample strobe, so the sample rate is 2·F_clk / (64·D). With a 10 MHz serial clock and D = 14 this gives 22.321 kHz. Because both transitions are counted, an odd D still gives evenly spaced strobes, provided the serial clock has a 50 % duty cycle.

The block runs on a faster system clock. It samples the serial clock through a synchroniser and finds its transitions there. The divisor comes from a 7-bit field and is limited to the range 5 to 128. A field value of 0 stands for 128. A new field value takes effect only at the next sample boundary, so a running frame never mixes two spacings. A chip with two codec channels places one instance per channel, and each instance has its own divisor field.

Top module: `sample_rate_divider`

## Requirements
- R1: While `rst` is high, `os_tick` and `fs_tick` are low, and the half-period and frame counters are cleared.
- R2: Every rising and every falling transition of `sclk_in` counts as one half-period. `os_tick` pulses once per D half-periods. With a steady serial clock of H system cycles per half-period, consecutive `os_tick` pulses are exactly D·H cycles apart.
- R3: `fs_tick` is high in the same cycle as every 64th `os_tick`, and never in any other cycle. Consecutive `fs_tick` pulses are 64·D·H cycles apart.
- R4: After reset the frame count starts from zero. The first `fs_tick` therefore comes with the 64th `os_tick` after reset.
- R5: A `div_field` value of 0 gives an effective divisor D of 128.
- R6: `div_field` values 1 to 4 are raised to D = 5.
- R7: `div_field` values 5 to 127 are used unchanged as D. Odd values give the same equal spacing as even ones.
- R8: A change of `div_field` during a frame has no effect until the cycle of the next `fs_tick`. All `os_tick` intervals up to and including that pulse keep the old D. The intervals after it use the new D. At reset the field is loaded directly.
- R9: `os_tick` and `fs_tick` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial interface clock; both of its transitions are counted |
| div_field | input | 7 | Divisor field (0 means 128; 1 to 4 are raised to 5) |
| os_tick | output | 1 | Oversampling strobe, one pulse per D half-periods |
| fs_tick | output | 1 | Sample strobe, one pulse per 64 oversampling strobes |

## Verification
Two things fall on one system cycle here. The first is that the sample strobe rises together with the 64th oversampling strobe. The second is that a pending divisor is taken over in the same cycle the frame wraps. The bench checks the first by counting oversampling strobes between sample strobes and by flagging any sample strobe seen without an oversampling strobe. It checks the second by changing the divisor field in the middle of a frame. It then requires the old spacing on every interval up to the sample strobe and the new spacing on the intervals right after it.

// File: rtl/srd_pkg.sv
package srd_pkg;

  localparam int unsigned FIELD_W_DEF  = 7;
  localparam int unsigned OS_RATIO_DEF = 64;
  localparam int unsigned DIV_LO_DEF   = 5;
  localparam int unsigned DIV_HI_DEF   = 128;

  // Map a raw divisor field onto the legal range; zero selects the top value.
  function automatic int unsigned eff_divisor(input int unsigned field,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (field == 0)  return hi;
    if (field < lo)  return lo;
    if (field > hi)  return hi;
    return field;
  endfunction

endpackage

// File: rtl/srd_edge_detect.sv
module srd_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  output logic half_evt
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], sclk_in};
  end

  // Any change between the two oldest stages is one half-period of sclk_in.
  assign half_evt = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

endmodule

// File: rtl/srd_div_hold.sv
module srd_div_hold
  import srd_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_DEF,
  parameter int unsigned DIV_LO  = DIV_LO_DEF,
  parameter int unsigned DIV_HI  = DIV_HI_DEF,
  localparam int unsigned HOLD_W = $clog2(DIV_HI + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] div_field,
  input  logic               load,
  output logic [HOLD_W-1:0]  div_q
);
  logic [HOLD_W-1:0] div_next;

  always_comb div_next = HOLD_W'(eff_divisor(int'(div_field), DIV_LO, DIV_HI));

  always_ff @(posedge clk) begin
    if (rst)       div_q <= div_next;
    else if (load) div_q <= div_next;
  end

  a_r8_reload_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_q));

  a_r5_divisor_in_range: assert property (@(posedge clk) disable iff (rst)
    (div_q >= HOLD_W'(DIV_LO)) && (div_q <= HOLD_W'(DIV_HI)));

endmodule

// File: rtl/srd_half_counter.sv
module srd_half_counter #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_evt,
  input  logic [HOLD_W-1:0] div_q,
  output logic              os_evt,
  output logic              os_tick
);
  logic [HOLD_W-1:0] cnt_q;

  assign os_evt = half_evt && (cnt_q == div_q - HOLD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= os_evt;
      if (half_evt) cnt_q <= os_evt ? '0 : cnt_q + HOLD_W'(1);
    end
  end

  a_r2_count_below_div: assert property (@(posedge clk) disable iff (rst)
    cnt_q < div_q);

  a_r2_idle_without_edge: assert property (@(posedge clk) disable iff (rst)
    !half_evt |=> $stable(cnt_q));

  a_r9_os_single_cycle: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick);

endmodule

// File: rtl/srd_frame_counter.sv
module srd_frame_counter #(
  parameter int unsigned OS_RATIO = 64,
  localparam int unsigned PH_W = $clog2(OS_RATIO)
) (
  input  logic clk,
  input  logic rst,
  input  logic os_evt,
  output logic fs_evt,
  output logic fs_tick
);
  logic [PH_W-1:0] ph_q;

  assign fs_evt = os_evt && (ph_q == PH_W'(OS_RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      fs_tick <= 1'b0;
    end else begin
      fs_tick <= fs_evt;
      if (os_evt) ph_q <= fs_evt ? '0 : ph_q + PH_W'(1);
    end
  end

  a_r4_phase_moves_on_os: assert property (@(posedge clk) disable iff (rst)
    !os_evt |=> $stable(ph_q));

  a_r9_fs_single_cycle: assert property (@(posedge clk) disable iff (rst)
    fs_tick |=> !fs_tick);

endmodule

// File: rtl/sample_rate_divider.sv
module sample_rate_divider
  import srd_pkg::*;
#(
  parameter int unsigned FIELD_W     = FIELD_W_DEF,
  parameter int unsigned OS_RATIO    = OS_RATIO_DEF,
  parameter int unsigned DIV_LO      = DIV_LO_DEF,
  parameter int unsigned DIV_HI      = DIV_HI_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_in,
  input  logic [FIELD_W-1:0] div_field,
  output logic               os_tick,
  output logic               fs_tick
);
  localparam int unsigned HOLD_W = $clog2(DIV_HI + 1);

  logic              half_evt;
  logic              os_evt;
  logic              fs_evt;
  logic [HOLD_W-1:0] div_q;

  srd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .half_evt(half_evt)
  );

  srd_div_hold #(.FIELD_W(FIELD_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_hold (
    .clk(clk), .rst(rst), .div_field(div_field), .load(fs_evt), .div_q(div_q)
  );

  srd_half_counter #(.HOLD_W(HOLD_W)) u_half (
    .clk(clk), .rst(rst), .half_evt(half_evt), .div_q(div_q),
    .os_evt(os_evt), .os_tick(os_tick)
  );

  srd_frame_counter #(.OS_RATIO(OS_RATIO)) u_frame (
    .clk(clk), .rst(rst), .os_evt(os_evt), .fs_evt(fs_evt), .fs_tick(fs_tick)
  );

  a_r3_fs_needs_os: assert property (@(posedge clk) disable iff (rst)
    fs_tick |-> os_tick);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> (!os_tick && !fs_tick));

endmodule

// File: tb/sample_rate_divider_test.sv
`timescale 1ns/100ps
module sample_rate_divider_test;
  localparam int H = 2;  // system cycles per serial half-period

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_in = 1'b0;
  logic [6:0] div_field = 7'd5;
  logic       os_tick, fs_tick;

  int    total = 0;
  int    bad = 0;
  longint cyc = 0;
  bit    done = 1'b0;

  sample_rate_divider uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .div_field(div_field),
    .os_tick(os_tick), .fs_tick(fs_tick)
  );

  initial forever #2.5 clk = ~clk;
  initial begin #1; forever #(5 * H) sclk_in = ~sclk_in; end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input int v);
    if (v == 0) return 128;
    if (v < 5)  return 5;
    return v;
  endfunction

  task automatic wait_os(output longint t, output bit f);
    do begin
      @(negedge clk);
      if (fs_tick && !os_tick) chk(1'b0, "R3 fs without os", 1, 0);
    end while (os_tick !== 1'b1);
    t = cyc;
    f = fs_tick;
  endtask

  task automatic do_reset(input int v);
    @(negedge clk);
    div_field = 7'(v);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(os_tick === 1'b0 && fs_tick === 1'b0, "R1 reset outputs", {os_tick, fs_tick}, 0);
    rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    longint t0, t1, tf;
    bit f;
    int n;

    // R4 / R3: frame structure with D = 5
    do_reset(5);
    n = 0;
    do begin wait_os(t0, f); n++; end while (!f);
    chk(n == 64, "R4 first fs on 64th os", n, 64);
    tf = t0;
    n = 0;
    do begin wait_os(t1, f); n++; end while (!f);
    chk(n == 64, "R3 os per frame", n, 64);
    chk(t1 - tf == 64 * 5 * H, "R3 fs period", t1 - tf, 64 * 5 * H);
    @(negedge clk);
    chk(os_tick === 1'b0 && fs_tick === 1'b0, "R9 single-cycle pulses", {os_tick, fs_tick}, 0);

    // R8: field change mid-frame, taken at next sample boundary only
    do_reset(6);
    do wait_os(t0, f); while (!f);
    for (int i = 0; i < 10; i++) wait_os(t0, f);
    @(negedge clk);
    div_field = 7'd9;
    n = 0;
    do begin
      wait_os(t1, f);
      chk(t1 - t0 == 6 * H, "R8 old spacing kept", t1 - t0, 6 * H);
      t0 = t1;
      n++;
    end while (!f);
    chk(n == 54, "R8 frame length", n, 54);
    for (int i = 0; i < 3; i++) begin
      wait_os(t1, f);
      chk(t1 - t0 == 9 * H, "R8 new spacing", t1 - t0, 9 * H);
      t0 = t1;
    end

    // R5 / R6 / R7: sweep of every field value
    for (int v = 0; v < 128; v++) begin
      longint ta, tb, tc;
      string req;
      req = (v == 0) ? "R5 zero field" : (v < 5) ? "R6 low clamp" : "R7 direct divisor";
      do_reset(v);
      wait_os(t0, f);
      wait_os(ta, f);
      wait_os(tb, f);
      wait_os(tc, f);
      chk(tb - ta == exp_div(v) * H, req, tb - ta, exp_div(v) * H);
      chk(tc - tb == exp_div(v) * H, "R2 os spacing", tc - tb, exp_div(v) * H);
    end

    finish_run();
  end
endmodule